// File: doc/BRIEF.md
# Cascaded Match Flag Priority Chain

This block merges the match results of several content-addressable memory devices, strung one after another in priority order, into a single active-low system match flag. Each stage stands for one device. It looks at its own match lines and at the flag coming from the stage above it, and passes an active-low flag down to the next stage. The flag of the last stage is the system match flag. The first stage sees a constant "no upstream match".

Each device access is framed by two strobes. `cyc_start` marks the start of an access, the point where the chip enable falls; at that point each stage samples its active-low chain-enable input. `cyc_end` marks the end of the access, the point where the chip enable rises; at that point every flag updates. The next values ripple through the whole chain in the same cycle, so one end strobe settles the system flag. A stage can be set to pass the upstream flag through unchanged, ignoring its own matches. A stage can also be forced back to "no match" when its active configuration set changes. Compare logic and the selection of the winning address are outside this block.

Top module: `mfc_chain`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every bit of `mf_n` and `sys_mf_n` is 1 after that edge.
- R2: An armed stage with `flag_en` at 1 and at least one of its `match_lines` bits at 1 drives its `mf_n` bit to 0 after the `cyc_end` edge.
- R3: An armed stage with `flag_en` at 1 drives 0 after `cyc_end` when the stage above it produces 0 on the same update, even if it has no local match.
- R4: An armed stage with `flag_en` at 1, no local match and a 1 from above drives 1 after `cyc_end`.
- R5: An armed stage with `flag_en` at 0 copies the value from above to its output after `cyc_end`, and its own match lines have no effect.
- R6: A stage is armed only if its `chain_en_n` bit was 0 at the most recent `cyc_start` edge. An unarmed stage drives 1 after `cyc_end`, whatever its matches or the value from above.
- R7: Without `cyc_end`, `cfg_switch` or reset, `mf_n` keeps its value, whatever the match lines do.
- R8: A `cfg_switch` bit at 1 at a rising edge makes that stage's `mf_n` bit 1 after the edge. This wins over a `cyc_end` in the same cycle, and stages below that stage then see a 1 from it.
- R9: `sys_mf_n` equals the last stage's `mf_n` bit. Stage 0 behaves as if the value from above were always 1.
- R10: One `cyc_end` settles the whole chain. A match in stage k sets every armed stage below it with `flag_en` at 1 to 0 on that same update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | Strobe marking the start of an access; each stage samples `chain_en_n` |
| cyc_end | input | 1 | Strobe marking the end of an access; all flags update |
| chain_en_n | input | NUM_STAGES | Active-low chain enable, one bit per stage |
| flag_en | input | NUM_STAGES | Local match flag enable, one bit per stage (1 = local matches count) |
| cfg_switch | input | NUM_STAGES | Configuration-change pulse, one bit per stage; forces the flag high |
| match_lines | input | NUM_STAGES*LINES | Local match lines; stage i owns bits [i*LINES +: LINES] |
| mf_n | output | NUM_STAGES | Registered active-low flag of every stage |
| sys_mf_n | output | 1 | System match flag (last stage) |

## Verification
A configuration change and the end-of-access update can land on the same clock edge, and they disagree about a stage's next value. The bench drives `cfg_switch` on a middle stage together with `cyc_end`, while a stage above it holds a match. The expected result is that the switched stage reads 1 and that the stages below it see that 1 rather than the rippled match. The scoreboard also checks that stages above the switched one still report the match.

// File: rtl/mfc_pkg.sv
// Package: shared types and helpers for the cascaded match flag chain.
// Assumes active-low flags throughout: 1 = no match, 0 = match.
package mfc_pkg;

    // Control view of one stage at the moment of an update
    typedef struct packed {
        logic armed;     // chain enable was low at the last access start
        logic flag_en;   // local matches are allowed to count
        logic cfg_clr;   // configuration switch forces no-match
        logic any_hit;   // at least one local match line asserted
    } stage_ctl_t;

    localparam logic FLAG_NONE = 1'b1;
    localparam logic FLAG_HIT  = 1'b0;

    // Next active-low flag of a stage from its controls and the value above
    function automatic logic next_flag(stage_ctl_t ctl, logic above_n);
        logic res;
        if (ctl.cfg_clr) begin
            res = FLAG_NONE;
        end else if (!ctl.armed) begin
            res = FLAG_NONE;
        end else if (!ctl.flag_en) begin
            res = above_n;
        end else begin
            res = (ctl.any_hit || (above_n == FLAG_HIT)) ? FLAG_HIT : FLAG_NONE;
        end
        return res;
    endfunction

endpackage

// File: rtl/mfc_arm_reg.sv
// Module: mfc_arm_reg
// Holds whether a stage takes part in the chain for the current access.
// Assumes cyc_start is a one-cycle strobe at the start of each access;
// the sampled value persists until the next strobe or reset.
module mfc_arm_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic chain_en_n,
    output logic armed
);

    // Sample the active-low chain enable at each access start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (cyc_start) begin
            armed <= ~chain_en_n;
        end
    end

endmodule

// File: rtl/mfc_hit_reduce.sv
// Module: mfc_hit_reduce
// Folds a stage's match lines into a single "any match" bit.
// Assumes LINES >= 1. The lines are split into fixed-size groups that are
// OR-ed first, then the group results are OR-ed, to keep the depth shallow.
module mfc_hit_reduce #(
    parameter int LINES = 8,
    parameter int GROUP = 4
) (
    input  logic [LINES-1:0] lines,
    output logic             any_hit
);

    localparam int NGRP   = (LINES + GROUP - 1) / GROUP;
    localparam int PADDED = NGRP * GROUP;

    logic [PADDED-1:0] padded;
    logic [NGRP-1:0]   grp_hit;

    // Pad the line vector with zeros up to whole groups
    always_comb begin
        padded              = '0;
        padded[LINES-1:0]   = lines;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        // OR of one group of match lines
        assign grp_hit[g] = |padded[g*GROUP +: GROUP];
    end

    // Final OR across the group results
    assign any_hit = |grp_hit;

endmodule

// File: rtl/mfc_stage.sv
// Module: mfc_stage
// One link of the chain: arms on access start, computes its next flag from
// its matches and the next flag of the stage above, registers it at access end.
// Assumes the stage above presents its next value combinationally (above_nxt_n),
// so a single cyc_end settles the entire chain.
module mfc_stage
    import mfc_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic             cyc_end,
    input  logic             chain_en_n,
    input  logic             flag_en,
    input  logic             cfg_switch,
    input  logic [LINES-1:0] match_lines,
    input  logic             above_nxt_n,
    output logic             flag_nxt_n,
    output logic             flag_n
);

    logic       armed;
    logic       any_hit;
    stage_ctl_t ctl;

    mfc_arm_reg u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_start  (cyc_start),
        .chain_en_n (chain_en_n),
        .armed      (armed)
    );

    mfc_hit_reduce #(
        .LINES (LINES),
        .GROUP (4)
    ) u_hit (
        .lines   (match_lines),
        .any_hit (any_hit)
    );

    // Gather the controls that decide the next flag
    always_comb begin
        ctl.armed   = armed;
        ctl.flag_en = flag_en;
        ctl.cfg_clr = cfg_switch;
        ctl.any_hit = any_hit;
    end

    // Next flag, also offered to the stage below
    assign flag_nxt_n = next_flag(ctl, above_nxt_n);

    // Register the flag at access end or on a configuration switch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_n <= FLAG_NONE;
        end else if (cyc_end || cfg_switch) begin
            flag_n <= flag_nxt_n;
        end
    end

endmodule

// File: rtl/mfc_chain.sv
// Module: mfc_chain (top)
// Links NUM_STAGES stages in priority order; stage 0 is the highest priority
// and sees a constant no-match from above. The last stage gives the system flag.
// Assumes all stages share the access strobes, as devices on one enable do.
module mfc_chain #(
    parameter int NUM_STAGES = 4,
    parameter int LINES      = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cyc_start,
    input  logic                        cyc_end,
    input  logic [NUM_STAGES-1:0]       chain_en_n,
    input  logic [NUM_STAGES-1:0]       flag_en,
    input  logic [NUM_STAGES-1:0]       cfg_switch,
    input  logic [NUM_STAGES*LINES-1:0] match_lines,
    output logic [NUM_STAGES-1:0]       mf_n,
    output logic                        sys_mf_n
);

    localparam int LAST = NUM_STAGES - 1;

    logic [NUM_STAGES:0] nxt_n;

    // Nothing above the first stage
    assign nxt_n[0] = mfc_pkg::FLAG_NONE;

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        mfc_stage #(
            .LINES (LINES)
        ) u_stage (
            .clk         (clk),
            .rst_n       (rst_n),
            .cyc_start   (cyc_start),
            .cyc_end     (cyc_end),
            .chain_en_n  (chain_en_n[i]),
            .flag_en     (flag_en[i]),
            .cfg_switch  (cfg_switch[i]),
            .match_lines (match_lines[i*LINES +: LINES]),
            .above_nxt_n (nxt_n[i]),
            .flag_nxt_n  (nxt_n[i+1]),
            .flag_n      (mf_n[i])
        );
    end

    // System flag is the output of the last stage
    assign sys_mf_n = mf_n[LAST];

endmodule

// File: rtl/mfc_chain_checker.sv
// Module: mfc_chain_checker
// Port-level properties of the chain, bound to mfc_chain. Keeps its own copy
// of the armed state, taken from the chain-enable pins at each access start.
module mfc_chain_checker #(
    parameter int NUM_STAGES = 4,
    parameter int LINES      = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cyc_start,
    input logic                        cyc_end,
    input logic [NUM_STAGES-1:0]       chain_en_n,
    input logic [NUM_STAGES-1:0]       flag_en,
    input logic [NUM_STAGES-1:0]       cfg_switch,
    input logic [NUM_STAGES*LINES-1:0] match_lines,
    input logic [NUM_STAGES-1:0]       mf_n,
    input logic                        sys_mf_n
);

    logic [NUM_STAGES-1:0] arm_seen;

    // Observer copy of which stages are armed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_seen <= '0;
        end else if (cyc_start) begin
            arm_seen <= ~chain_en_n;
        end
    end

    // R1: reset leaves every flag high
    a_r1_reset_high: assert property (@(posedge clk)
        !rst_n |=> (&mf_n && sys_mf_n));

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_chk
        // R8: configuration switch clears the stage
        a_r8_cfg_clears: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_switch[i] |=> mf_n[i]);

        // R7: flag holds when nothing updates it
        a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!cyc_end && !cfg_switch[i]) |=> $stable(mf_n[i]));

        // R6: an unarmed stage reports no match
        a_r6_unarmed_high: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc_end && !arm_seen[i] && !cyc_start) |=> mf_n[i]);

        // R2: armed local match drives low
        a_r2_local_hit: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc_end && !cyc_start && arm_seen[i] && flag_en[i] && !cfg_switch[i]
             && (|match_lines[i*LINES +: LINES])) |=> !mf_n[i]);

        if (i == 0) begin : g_top
            // R9: first stage in pass-through sees no upstream match
            a_r9_first_passthru: assert property (@(posedge clk) disable iff (!rst_n)
                (cyc_end && !cyc_start && arm_seen[i] && !flag_en[i]) |=> mf_n[i]);
        end else begin : g_below
            // R5: pass-through copies the stage above
            a_r5_passthru: assert property (@(posedge clk) disable iff (!rst_n)
                (cyc_end && !cyc_start && arm_seen[i] && !flag_en[i] && !cfg_switch[i])
                |=> (mf_n[i] == mf_n[i-1]));

            // R3: an upstream match propagates through an enabled stage
            a_r3_upstream: assert property (@(posedge clk) disable iff (!rst_n)
                (cyc_end && !cyc_start && arm_seen[i] && flag_en[i] && !cfg_switch[i])
                |=> (mf_n[i-1] || !mf_n[i]));
        end
    end

    // R9: system flag follows the last stage
    a_r9_system_flag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sys_mf_n == mf_n[NUM_STAGES-1]));

endmodule

bind mfc_chain mfc_chain_checker #(
    .NUM_STAGES (NUM_STAGES),
    .LINES      (LINES)
) u_mfc_chain_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_start   (cyc_start),
    .cyc_end     (cyc_end),
    .chain_en_n  (chain_en_n),
    .flag_en     (flag_en),
    .cfg_switch  (cfg_switch),
    .match_lines (match_lines),
    .mf_n        (mf_n),
    .sys_mf_n    (sys_mf_n)
);

// File: tb/mfc_chain_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard style. Driver tasks apply stimulus, compute the expected
// flags from the requirements and queue them with the cycle they are due;
// a monitor compares them at the falling edge.
module mfc_chain_bench;

    localparam int N = 4;
    localparam int L = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cyc_start = 1'b0;
    logic           cyc_end = 1'b0;
    logic [N-1:0]   chain_en_n = '1;
    logic [N-1:0]   flag_en = '1;
    logic [N-1:0]   cfg_switch = '0;
    logic [N*L-1:0] match_lines = '0;
    logic [N-1:0]   mf_n;
    logic           sys_mf_n;

    typedef struct {
        int           due;
        logic [N-1:0] exp;
        string        req;
    } item_t;

    item_t        sb[$];
    int           cyc_cnt = 0;
    int           checks = 0;
    int           errors = 0;
    logic [N-1:0] arm_m = '0;
    logic [N-1:0] cur_m = '1;

    mfc_chain #(.NUM_STAGES(N), .LINES(L)) u_mfc_chain (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_start   (cyc_start),
        .cyc_end     (cyc_end),
        .chain_en_n  (chain_en_n),
        .flag_en     (flag_en),
        .cfg_switch  (cfg_switch),
        .match_lines (match_lines),
        .mf_n        (mf_n),
        .sys_mf_n    (sys_mf_n)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    // Monitor: compare due items at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc_cnt) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (mf_n !== it.exp) begin
                errors++;
                $display("FAIL %s: mf_n actual %b expected %b", it.req, mf_n, it.exp);
            end
            checks++;
            if (sys_mf_n !== it.exp[N-1]) begin
                errors++;
                $display("FAIL R9 (%s): sys_mf_n actual %b expected %b",
                         it.req, sys_mf_n, it.exp[N-1]);
            end
        end
    end

    // Spread per-stage hit bits onto a chosen match line
    function automatic logic [N*L-1:0] lines_of(logic [N-1:0] hit, int line);
        logic [N*L-1:0] v = '0;
        for (int i = 0; i < N; i++) v[i*L + line] = hit[i];
        return v;
    endfunction

    // Expected update of the chain from the requirements
    function automatic logic [N-1:0] model(logic [N-1:0] arm, logic [N-1:0] fe,
                                           logic [N-1:0] hit, logic [N-1:0] cfg);
        logic [N-1:0] r;
        logic above = 1'b1;
        for (int i = 0; i < N; i++) begin
            if (cfg[i])       r[i] = 1'b1;
            else if (!arm[i]) r[i] = 1'b1;
            else if (!fe[i])  r[i] = above;
            else              r[i] = ~(hit[i] | ~above);
            above = r[i];
        end
        return r;
    endfunction

    task automatic push(logic [N-1:0] exp, string req);
        item_t it;
        it.due = cyc_cnt + 1;
        it.exp = exp;
        it.req = req;
        sb.push_back(it);
    endtask

    // One full access: start strobe, then end strobe (with optional cfg)
    task automatic access(logic [N-1:0] en_n, logic [N-1:0] fe, logic [N-1:0] hit,
                          int line, logic [N-1:0] cfg, string req);
        @(negedge clk);
        chain_en_n  = en_n;
        cyc_start   = 1'b1;
        @(negedge clk);
        cyc_start   = 1'b0;
        chain_en_n  = '1;
        flag_en     = fe;
        match_lines = lines_of(hit, line);
        cyc_end     = 1'b1;
        cfg_switch  = cfg;
        arm_m       = ~en_n;
        cur_m       = model(arm_m, fe, hit, cfg);
        push(cur_m, req);
        @(negedge clk);
        cyc_end     = 1'b0;
        cfg_switch  = '0;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push('1, "R1 reset state");
        @(negedge clk);
        @(negedge clk);

        // R2 / R10: local hit in stage 2 pulls 2 and 3 low
        access('0, '1, 4'b0100, 3, '0, "R2 R10 hit at stage 2");
        // R3 / R10: hit at stage 0 ripples through everything
        access('0, '1, 4'b0001, 7, '0, "R3 R10 hit at stage 0");
        // R4: no matches anywhere
        access('0, '1, 4'b0000, 0, '0, "R4 no match");
        // R5: stage 1 pass-through ignores its own hit
        access('0, 4'b1101, 4'b0010, 5, '0, "R5 pass-through ignores local hit");
        // R5: pass-through still forwards an upstream match
        access('0, 4'b1101, 4'b0001, 1, '0, "R5 pass-through forwards upstream");
        // R9: stage 0 pass-through sees no match above
        access('0, 4'b1110, 4'b0001, 2, '0, "R9 first stage above is high");
        // R6: stage 2 not armed breaks the chain
        access(4'b0100, '1, 4'b0101, 6, '0, "R6 unarmed stage stays high");
        // R6: nothing armed
        access('1, '1, 4'b1111, 4, '0, "R6 chain disabled");

        // Set all low, then R7: hold while lines change and no update
        access('0, '1, 4'b0001, 0, '0, "R10 all low before hold");
        @(negedge clk);
        match_lines = '0;
        cyc_start   = 1'b1;
        chain_en_n  = '1;
        @(negedge clk);
        cyc_start   = 1'b0;
        match_lines = '1;
        repeat (2) @(negedge clk);
        push(cur_m, "R7 hold without update");
        @(negedge clk);

        // R8: cfg switch alone on stage 0, others hold
        cfg_switch = 4'b0001;
        cur_m[0]   = 1'b1;
        push(cur_m, "R8 cfg switch alone");
        @(negedge clk);
        cfg_switch = '0;
        @(negedge clk);

        // R8: cfg switch on stage 1 in the same cycle as the update
        access('0, '1, 4'b0001, 3, 4'b0010, "R8 cfg switch wins over update");

        // R1: reset in the middle of operation
        access('0, '1, 4'b1000, 2, '0, "R2 hit at last stage");
        @(negedge clk);
        rst_n = 1'b0;
        push('1, "R1 reset after activity");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule